// File: doc/BRIEF.md
# Digit-Serial Interleaved Modular Multiplier

This block computes (A × B) mod M for unsigned operands of a parameterised width `W` (512 bits by default). A start strobe captures the three operands into internal registers, and the block then runs on its own until a one-cycle done pulse marks the result as valid.

The work has three phases. A fixed 48-cycle setup phase builds three tables: the multiples 0·A to 15·A, the two's-complement negations of 0·M to 47·M, and a rounded-up 12-bit threshold for each multiple of M. A digit phase then consumes B four bits per cycle, starting with the top digit. In each cycle it multiplies the running value by 16, adds the selected multiple of A, and adds one negated multiple of M. The running value stays in carry-save form, as a sum vector and a carry vector. The multiple of M is chosen by comparing a 12-bit estimate, taken from the top bits of the three addends, against the thresholds. A final cycle merges the two vectors with one carry-propagate add and applies up to two conditional subtractions of M.

The operands must meet four conditions: M is odd, the top bit of M (bit W−1) is set, A < M, and B < M. Under these conditions the running value stays below 2M after every digit. The result is unspecified for any other operands.

Top module: `dsmod_mul`

## Requirements
- R1: When done is high, result equals (A × B) mod M for the operands captured at the accepted start, and result < M. This holds when M is odd, M has bit W−1 set, and A, B < M.
- R2: ready is high exactly when the block is idle. It goes low in the cycle after an accepted start (start high while ready is high) and is high again in the cycle where done is high.
- R3: done is a single-cycle pulse. It rises 49 + W/4 clock edges after the edge that accepts start: 48 setup edges, W/4 digit edges and one finishing edge.
- R4: Operands are sampled only at the accepting edge. Changes on a_in, b_in or m_in while busy do not affect the result.
- R5: start asserted while ready is low is ignored. The result still belongs to the first operands, and the done timing of R3 is unchanged.
- R6: Edge operands give exact results: A = 0 gives 0, A = 1 gives B, and A = B = M−1 gives 1.
- R7: result changes only in the cycle where done is high, and holds its value at all other times.
- R8: After reset, ready is 1, done is 0 and result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiply; accepted only while ready is high |
| ready | output | 1 | Block idle, can accept start |
| a_in | input | W | Multiplicand A, sampled on accept |
| b_in | input | W | Multiplier B, sampled on accept, consumed four bits per cycle from the top |
| m_in | input | W | Modulus M, sampled on accept |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | W | (A × B) mod M, held until the next done |

## Verification
The hardest condition to reach is a digit step whose quotient estimate sits right at a threshold edge or wraps below zero. In these steps the running value lands close to M plus the estimate slack, or the leftover from the previous step is tiny. Only specific moduli and operands steer the carry-save value there. The bench therefore sweeps every pairing of 0, 1, 2, M−2 and M−1 against moduli at both ends of the allowed range (just above 2^(W−1) and all ones), then adds several hundred random operand sets at W = 64. Each result is checked against a wide product-and-remainder computed in the bench.

// File: rtl/dsmod_mul.sv
module dsmod_mul #(
  parameter int W = 512
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic         ready,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] m_in,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int X    = W + 6;
  localparam int P    = W - 6;
  localparam int TW   = X - P;
  localparam int ND   = W / 4;
  localparam int NA   = 16;
  localparam int NQ   = 48;
  localparam int CMAX = (ND > NQ) ? ND : NQ;
  localparam int CW   = $clog2(CMAX);

  typedef enum logic [1:0] {IDLE, PRE, LOOP, FIN} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic [5:0]    idx;
  logic [W-1:0]  a_q, b_q, m_q;
  logic [X-1:0]  acc_a, acc_m, s_q, c_q;
  logic [X-1:0]  mul_a [NA];
  logic [X-1:0]  neg_m [NQ];
  logic [TW-1:0] thr   [NQ];

  logic [3:0]    dig;
  logic [X-1:0]  s16, c16, dmul, nm, s1, c1, s2, c2, mx, rsum, r1;
  logic [TW-1:0] est;
  logic [5:0]    qsel;
  logic [W-1:0]  res_n;

  assign ready = (st == IDLE);
  assign idx   = cnt[5:0];
  assign dig   = b_q[W-1 -: 4];
  assign s16   = {s_q[X-5:0], 4'b0};
  assign c16   = {c_q[X-5:0], 4'b0};
  assign dmul  = mul_a[dig];
  assign est   = s16[X-1:P] + c16[X-1:P] + dmul[X-1:P];

  always_comb begin
    qsel = '0;
    if (est[TW-1:TW-2] != 2'b11)
      for (int k = 1; k < NQ; k++)
        if (thr[k] <= est) qsel = qsel + 6'd1;
  end

  assign nm   = neg_m[qsel];
  assign s1   = s16 ^ c16 ^ dmul;
  assign c1   = ((s16 & c16) | (s16 & dmul) | (c16 & dmul)) << 1;
  assign s2   = s1 ^ c1 ^ nm;
  assign c2   = ((s1 & c1) | (s1 & nm) | (c1 & nm)) << 1;

  assign mx    = {6'b0, m_q};
  assign rsum  = s_q + c_q;
  assign r1    = (rsum >= mx) ? rsum - mx : rsum;
  assign res_n = (r1 >= mx) ? r1[W-1:0] - m_q : r1[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      done   <= 1'b0;
      result <= '0;
      a_q    <= '0;
      b_q    <= '0;
      m_q    <= '0;
      acc_a  <= '0;
      acc_m  <= '0;
      s_q    <= '0;
      c_q    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          a_q   <= a_in;
          b_q   <= b_in;
          m_q   <= m_in;
          acc_a <= '0;
          acc_m <= '0;
          cnt   <= '0;
          st    <= PRE;
        end
        PRE: begin
          if (idx < 6'(NA)) mul_a[idx[3:0]] <= acc_a;
          neg_m[idx] <= ~acc_m + 1'b1;
          thr[idx]   <= acc_m[X-1:P] + {{(TW-1){1'b0}}, |acc_m[P-1:0]};
          acc_a      <= acc_a + {6'b0, a_q};
          acc_m      <= acc_m + {6'b0, m_q};
          if (cnt == CW'(NQ-1)) begin
            cnt <= '0;
            s_q <= '0;
            c_q <= '0;
            st  <= LOOP;
          end else cnt <= cnt + 1'b1;
        end
        LOOP: begin
          s_q <= s2;
          c_q <= c2;
          b_q <= b_q << 4;
          if (cnt == CW'(ND-1)) st <= FIN;
          else cnt <= cnt + 1'b1;
        end
        default: begin
          result <= res_n;
          done   <= 1'b1;
          st     <= IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/dsmod_mul_chk.sv
module dsmod_mul_chk #(
  parameter int W = 512
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         ready,
  input logic         done,
  input logic [W-1:0] result,
  input logic [W-1:0] m_q
);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);

  // R1
  result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < m_q));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

bind dsmod_mul dsmod_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
  .done(done), .result(result), .m_q(m_q)
);

// File: tb/sim_dsmod_mul.sv
`timescale 1ns/1ps
module sim_dsmod_mul;
  localparam int W   = 64;
  localparam int LAT = 49 + W / 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         ready, done;
  logic [W-1:0] a_in = '0, b_in = '0, m_in = '0;
  logic [W-1:0] result;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  dsmod_mul #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
    .a_in(a_in), .b_in(b_in), .m_in(m_in), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_mod(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] m);
    logic [2*W-1:0] p;
    p = ({{W{1'b0}}, a} * {{W{1'b0}}, b}) % {{W{1'b0}}, m};
    return p[W-1:0];
  endfunction

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] m,
                        input bit poke, input string tag);
    logic [W-1:0] exp;
    logic [W-1:0] held;
    int n;
    exp = ref_mod(a, b, m);
    a_in = a; b_in = b; m_in = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a_in = ~a; b_in = b ^ 64'h5a5a; m_in = m ^ 64'h1234_0000;  // R4 garbage while busy
    chk(!ready, "R2 ready low while busy", W'(ready), '0);
    n = 1;
    while (!done && n < 200) begin
      start = (poke && (n == 7 || n == 55)) ? 1'b1 : 1'b0;  // R5 start while busy
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(done && n == LAT + 1, "R3 done latency", W'(n), W'(LAT + 1));
    chk(result == exp, tag, result, exp);
    chk(ready, "R2 ready with done", W'(ready), W'(1));
    held = result;
    @(negedge clk);
    chk(!done, "R3 done single pulse", W'(done), '0);
    @(negedge clk);
    chk(result == held, "R7 result held", result, held);
  endtask

  initial begin
    #(5.0 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] ms [4];
    logic [W-1:0] ops [5];
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(ready == 1'b1, "R8 ready after reset", W'(ready), W'(1));
    chk(done == 1'b0, "R8 done after reset", W'(done), '0);
    chk(result == '0, "R8 result after reset", result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1 && done == 1'b0, "R8 idle after release", W'({ready, done}), W'(2));

    ms[0] = 64'h8000_0000_0000_0001;
    ms[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    ms[2] = 64'hC000_0000_0000_0003;
    ms[3] = {$urandom, $urandom} | 64'h8000_0000_0000_0001;
    for (int i = 0; i < 4; i++) begin
      ops[0] = '0; ops[1] = 64'd1; ops[2] = 64'd2; ops[3] = ms[i] - 1; ops[4] = ms[i] - 2;
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++)
          run_op(ops[x], ops[y], ms[i], 1'b0, "R6 edge operand result");
    end

    // R6 explicit edge identities
    run_op('0, 64'h1234, ms[3], 1'b0, "R6 zero times B");
    run_op(64'd1, 64'h7777_1234, ms[0], 1'b0, "R6 one times B");
    run_op(ms[1] - 1, ms[1] - 1, ms[1], 1'b0, "R6 (M-1)^2 gives 1");
    chk(result == 64'd1, "R6 (M-1)^2 value", result, 64'd1);

    // R5 start pulses while busy are ignored
    for (int i = 0; i < 20; i++) begin
      logic [W-1:0] m;
      m = {$urandom, $urandom} | 64'h8000_0000_0000_0001;
      run_op({$urandom, $urandom} % m, {$urandom, $urandom} % m, m, 1'b1, "R5 busy start ignored");
    end

    // R1 R4 random sweep
    for (int i = 0; i < 800; i++) begin
      logic [W-1:0] m;
      m = {$urandom, $urandom} | 64'h8000_0000_0000_0001;
      run_op({$urandom, $urandom} % m, {$urandom, $urandom} % m, m, 1'b0, "R1 random product mod");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule